// File: doc/BRIEF.md
# Question-answer watchdog sequence checker

This block judges the answers a controller sends during one question-answer watchdog cycle. A cycle opens with a first response window and is followed at once by a second one. Each window has a length in clock ticks that software can set. The controller sends answers as single-tick strobes, each marked correct or incorrect. The block tallies them with a 2-bit answer counter. It notes whether each answer arrived in the first or the second window. A cycle closes at the fourth answer, or when the second window runs out, whichever happens first.

When a cycle closes, the block does four things. It merges that cycle's error events into four sticky status flags. It steps a saturating 3-bit fail counter up or down. It raises a new-question request only for a passing cycle, and it pulses a cycle-start marker. Question generation and reference answers are handled elsewhere: the block receives only the correct/incorrect verdict for each answer.

Top module: `qa_wdog_judge`

## Requirements
- R1: A cycle passes only when it has exactly three answers in window one and a fourth in window two, all four correct. On the tick after the fourth answer, `new_q` and `cyc_start` are both 1, no flag is newly set, and `fail_cnt` drops by one but never below 0.
- R2: The fourth answer of a cycle ends that cycle immediately, in whichever window it lands. `cyc_start` is 1 on the next tick, and a new window one begins on that tick.
- R3: If all four answers arrive inside window one, `flag_early` is set when the cycle closes.
- R4: Any incorrect answer received in either window sets `flag_wrong` when the cycle closes.
- R5: If window one ends with fewer than three answers received, `flag_seq` is set when the cycle closes. Window one holding exactly three answers gives no sequence error.
- R6: If window two expires before a fourth answer arrives, `flag_tmo` is set, and `cyc_start` is 1 on the tick after the last tick of window two.
- R7: Every failing cycle raises `fail_cnt` by one, saturating at 7, and leaves `new_q` at 0. `fail_cnt` changes only on a `cyc_start` tick. Reset gives `fail_cnt` = 0.
- R8: The four flags are sticky. They change only on a `cyc_start` tick, or one tick after `clr_req`, which clears them. If a clear and a cycle close fall on the same tick, that cycle's events are kept. Reset clears all flags.
- R9: `fail_out` is 1 exactly while `fail_cnt` is greater than `fail_thr`.
- R10: Window one covers the first `win1_len` ticks of a cycle, counting the `cyc_start` tick. Window two covers the next `win2_len` ticks. A length of 0 is treated as 1. An answer on the last tick of a window counts toward that window. `cyc_start` is 0 on every other tick of the cycle, and it is 1 on the first tick after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ans_vld | input | 1 | One-tick answer strobe |
| ans_ok | input | 1 | With `ans_vld`: 1 means the answer is correct |
| win1_len | input | TW | Length of window one in ticks |
| win2_len | input | TW | Length of window two in ticks |
| clr_req | input | 1 | Clears the four status flags |
| fail_thr | input | 3 | Threshold that `fail_out` compares against |
| flag_early | output | 1 | Sticky: four answers arrived inside window one |
| flag_wrong | output | 1 | Sticky: an incorrect answer was seen |
| flag_seq | output | 1 | Sticky: window one closed short of three answers |
| flag_tmo | output | 1 | Sticky: window two expired |
| fail_cnt | output | 3 | Saturating fail counter |
| fail_out | output | 1 | Fail counter is above the threshold |
| new_q | output | 1 | Pulse: the cycle passed, so a new question is needed |
| cyc_start | output | 1 | Pulse: first tick of a cycle |

## Verification
The hardest conditions to reach from the ports are two answer placements. In one, an answer lands exactly on the last tick of window one. In the other, a fourth answer lands inside window one. Either can happen only with certain windows and only when the answer strobes sit at the right places in that cycle. The bench uses a four-tick first window and a three-tick second window. It drives all 2187 patterns of none/correct/incorrect over the seven ticks, so every boundary placement and every mix of answers occurs. A separate bench model predicts each cycle's close, flags and counter. Directed cycles then cover sticky flags, a clear that coincides with a cycle close, zero window lengths, and counter saturation at both ends.

// File: rtl/qa_wdog_pkg.sv
package qa_wdog_pkg;

    // Width of the saturating fail counter.
    localparam int unsigned QA_FAIL_W = 3;
    localparam logic [QA_FAIL_W-1:0] QA_FAIL_MAX = {QA_FAIL_W{1'b1}};

    // Number of answers that closes a cycle, minus one (counter value at the last answer).
    localparam logic [1:0] QA_LAST_IDX = 2'd3;
    // Answers needed in window one for a clean sequence.
    localparam logic [2:0] QA_W1_NEED = 3'd3;

    typedef enum logic {
        PH_W1 = 1'b0,
        PH_W2 = 1'b1
    } qa_phase_e;

    typedef struct packed {
        logic early;
        logic wrong;
        logic seq;
        logic tmo;
    } qa_flags_t;

    typedef struct packed {
        logic      done;
        logic      pass;
        qa_flags_t evt;
    } qa_verdict_t;

    // One step of the fail counter: down on a pass, up on a fail, clamped at both ends.
    function automatic logic [QA_FAIL_W-1:0] fail_step(
        input logic [QA_FAIL_W-1:0] cur,
        input logic                 pass
    );
        logic [QA_FAIL_W-1:0] nxt;
        if (pass) begin
            nxt = (cur == '0) ? cur : cur - 1'b1;
        end else begin
            nxt = (cur == QA_FAIL_MAX) ? cur : cur + 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/qa_win_timer.sv
module qa_win_timer
    import qa_wdog_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [TW-1:0] win1_len,
    input  logic [TW-1:0] win2_len,
    output qa_phase_e     phase,
    output logic          w1_last,
    output logic          w2_last
);

    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] tick;
    logic [TW-1:0] eff1;
    logic [TW-1:0] eff2;

    // A zero length behaves as a single tick.
    always_comb begin
        eff1 = (win1_len == '0) ? ONE : win1_len;
        eff2 = (win2_len == '0) ? ONE : win2_len;
    end

    always_comb begin
        w1_last = (phase == PH_W1) && (tick == eff1 - ONE);
        w2_last = (phase == PH_W2) && (tick == eff2 - ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_W1;
            tick  <= '0;
        end else if (restart) begin
            phase <= PH_W1;
            tick  <= '0;
        end else if (w1_last) begin
            phase <= PH_W2;
            tick  <= '0;
        end else begin
            tick  <= tick + ONE;
        end
    end

endmodule

// File: rtl/qa_ans_tally.sv
module qa_ans_tally
    import qa_wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ans_vld,
    input  logic        ans_ok,
    input  qa_phase_e   phase,
    input  logic        w1_last,
    input  logic        w2_last,
    output qa_verdict_t verdict
);

    logic [1:0] cnt;
    logic       wrong_acc;
    logic       seq_acc;

    logic       in_w1;
    logic       bad_now;
    logic       fourth;
    logic       short_w1;
    logic       tmo_now;
    logic [2:0] cnt_incl;

    always_comb begin
        in_w1    = (phase == PH_W1);
        bad_now  = ans_vld && !ans_ok;
        fourth   = ans_vld && (cnt == QA_LAST_IDX);
        cnt_incl = {1'b0, cnt} + {2'b00, ans_vld};
        // An answer on the closing tick of window one still counts for it.
        short_w1 = w1_last && (cnt_incl < QA_W1_NEED);
        tmo_now  = w2_last && !fourth;
    end

    always_comb begin
        verdict.evt.early = fourth && in_w1;
        verdict.evt.wrong = wrong_acc || bad_now;
        verdict.evt.seq   = seq_acc || short_w1;
        verdict.evt.tmo   = tmo_now;
        verdict.done      = fourth || tmo_now;
        verdict.pass      = fourth && !in_w1 && !verdict.evt.wrong && !verdict.evt.seq;
    end

    always_ff @(posedge clk) begin
        if (rst || verdict.done) begin
            cnt       <= '0;
            wrong_acc <= 1'b0;
            seq_acc   <= 1'b0;
        end else begin
            cnt       <= cnt_incl[1:0];
            wrong_acc <= wrong_acc || bad_now;
            seq_acc   <= seq_acc || short_w1;
        end
    end

endmodule

// File: rtl/qa_status_keep.sv
module qa_status_keep
    import qa_wdog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  qa_verdict_t          verdict,
    input  logic                 clr_req,
    input  logic [QA_FAIL_W-1:0] fail_thr,
    output qa_flags_t            flags,
    output logic [QA_FAIL_W-1:0] fail_cnt,
    output logic                 fail_out,
    output logic                 new_q,
    output logic                 cyc_start
);

    localparam int unsigned NFLAG = $bits(qa_flags_t);

    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] evt_v;

    assign evt_v = verdict.evt;

    // Each flag: a clear drops it, a closing cycle's event sets it, set wins.
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[g] <= 1'b0;
            end else begin
                flag_q[g] <= (flag_q[g] && !clr_req) || (verdict.done && evt_v[g]);
            end
        end
    end

    assign flags = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_cnt  <= '0;
            new_q     <= 1'b0;
            cyc_start <= 1'b1;
        end else begin
            if (verdict.done) begin
                fail_cnt <= fail_step(fail_cnt, verdict.pass);
            end
            new_q     <= verdict.done && verdict.pass;
            cyc_start <= verdict.done;
        end
    end

    assign fail_out = (fail_cnt > fail_thr);

endmodule

// File: rtl/qa_wdog_judge.sv
module qa_wdog_judge
    import qa_wdog_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ans_vld,
    input  logic                 ans_ok,
    input  logic [TW-1:0]        win1_len,
    input  logic [TW-1:0]        win2_len,
    input  logic                 clr_req,
    input  logic [QA_FAIL_W-1:0] fail_thr,
    output logic                 flag_early,
    output logic                 flag_wrong,
    output logic                 flag_seq,
    output logic                 flag_tmo,
    output logic [QA_FAIL_W-1:0] fail_cnt,
    output logic                 fail_out,
    output logic                 new_q,
    output logic                 cyc_start
);

    qa_phase_e   phase;
    logic        w1_last;
    logic        w2_last;
    qa_verdict_t verdict;
    qa_flags_t   flags;

    qa_win_timer #(.TW(TW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .restart  (verdict.done),
        .win1_len (win1_len),
        .win2_len (win2_len),
        .phase    (phase),
        .w1_last  (w1_last),
        .w2_last  (w2_last)
    );

    qa_ans_tally tally_i (
        .clk     (clk),
        .rst     (rst),
        .ans_vld (ans_vld),
        .ans_ok  (ans_ok),
        .phase   (phase),
        .w1_last (w1_last),
        .w2_last (w2_last),
        .verdict (verdict)
    );

    qa_status_keep keep_i (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .clr_req   (clr_req),
        .fail_thr  (fail_thr),
        .flags     (flags),
        .fail_cnt  (fail_cnt),
        .fail_out  (fail_out),
        .new_q     (new_q),
        .cyc_start (cyc_start)
    );

    assign flag_early = flags.early;
    assign flag_wrong = flags.wrong;
    assign flag_seq   = flags.seq;
    assign flag_tmo   = flags.tmo;

endmodule

// File: rtl/qa_wdog_judge_chk.sv
module qa_wdog_judge_chk
    import qa_wdog_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 clr_req,
    input logic                 flag_early,
    input logic                 flag_wrong,
    input logic                 flag_seq,
    input logic                 flag_tmo,
    input logic [QA_FAIL_W-1:0] fail_cnt,
    input logic                 new_q,
    input logic                 cyc_start
);

    logic [3:0] fl;
    assign fl = {flag_early, flag_wrong, flag_seq, flag_tmo};

    // R1
    pass_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (new_q && !$past(clr_req)) |-> (fl == $past(fl)));

    // R1
    pass_steps_down_chk: assert property (@(posedge clk) disable iff (rst)
        (new_q && ($past(fail_cnt) != '0)) |-> (fail_cnt == $past(fail_cnt) - 1'b1));

    // R2
    newq_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        new_q |-> cyc_start);

    // R7
    fail_steps_up_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && !new_q && !$past(rst) && ($past(fail_cnt) != QA_FAIL_MAX))
        |-> (fail_cnt == $past(fail_cnt) + 1'b1));

    // R7
    cnt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cyc_start |-> $stable(fail_cnt));

    // R8
    flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(fl) & ~fl) != 4'b0000) |-> $past(clr_req));

    // R8
    flag_move_chk: assert property (@(posedge clk) disable iff (rst)
        ((fl != $past(fl)) && !$past(clr_req)) |-> cyc_start);

endmodule

bind qa_wdog_judge qa_wdog_judge_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .clr_req    (clr_req),
    .flag_early (flag_early),
    .flag_wrong (flag_wrong),
    .flag_seq   (flag_seq),
    .flag_tmo   (flag_tmo),
    .fail_cnt   (fail_cnt),
    .new_q      (new_q),
    .cyc_start  (cyc_start)
);

// File: tb/qa_wdog_judge_tb_top.sv
module qa_wdog_judge_tb_top;

    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          ans_vld;
    logic          ans_ok;
    logic [TW-1:0] win1_len;
    logic [TW-1:0] win2_len;
    logic          clr_req;
    logic [2:0]    fail_thr;
    logic          flag_early;
    logic          flag_wrong;
    logic          flag_seq;
    logic          flag_tmo;
    logic [2:0]    fail_cnt;
    logic          fail_out;
    logic          new_q;
    logic          cyc_start;

    always #4 clk = ~clk;

    qa_wdog_judge #(.TW(TW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .ans_vld    (ans_vld),
        .ans_ok     (ans_ok),
        .win1_len   (win1_len),
        .win2_len   (win2_len),
        .clr_req    (clr_req),
        .fail_thr   (fail_thr),
        .flag_early (flag_early),
        .flag_wrong (flag_wrong),
        .flag_seq   (flag_seq),
        .flag_tmo   (flag_tmo),
        .fail_cnt   (fail_cnt),
        .fail_out   (fail_out),
        .new_q      (new_q),
        .cyc_start  (cyc_start)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // Per-tick stimulus: 0 = no answer, 1 = correct answer, 2 = incorrect answer.
    int pat [16];
    logic [3:0] exp_fl;
    int exp_cnt;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_pat();
        for (int k = 0; k < 16; k++) pat[k] = 0;
    endtask

    // Runs one cycle from its first tick; called and returning at a falling edge.
    task automatic run_cycle(input int l1, input int l2, input int clr_tick,
                             input int thr, input string lbl);
        int e1;
        int e2;
        int cnt;
        int i;
        bit wr;
        bit sq;
        bit done;
        bit early;
        bit tmo;
        bit pass;
        bit v;
        bit in1;
        bit clr_seen;
        e1 = (l1 == 0) ? 1 : l1;
        e2 = (l2 == 0) ? 1 : l2;
        cnt = 0; i = 0; wr = 0; sq = 0; done = 0;
        early = 0; tmo = 0; pass = 0; clr_seen = 0;
        while (!done) begin
            if (i == 0) begin
                win1_len = TW'(l1);
                win2_len = TW'(l2);
                fail_thr = 3'(thr);
            end
            v = (pat[i] != 0);
            ans_vld = v;
            ans_ok  = (pat[i] == 1);
            clr_req = (i == clr_tick);
            if (i == clr_tick) clr_seen = 1;
            in1 = (i < e1);
            if (v && pat[i] == 2) wr = 1;
            if (in1 && i == e1 - 1 && cnt + int'(v) < 3) sq = 1;
            if (v && cnt == 3) begin
                done  = 1;
                early = in1;
                pass  = !in1 && !wr && !sq;
            end else if (!in1 && i == e1 + e2 - 1) begin
                done = 1;
                tmo  = 1;
            end
            cnt += int'(v);
            @(posedge clk);
            @(negedge clk);
            ans_vld = 1'b0;
            clr_req = 1'b0;
            if (!done) chk({lbl, " R10 cyc_start mid-cycle"}, int'(cyc_start), 0);
            i++;
        end
        exp_fl = (clr_seen ? 4'b0000 : exp_fl) | {early, wr, sq, tmo};
        if (pass) exp_cnt = (exp_cnt > 0) ? exp_cnt - 1 : 0;
        else      exp_cnt = (exp_cnt < 7) ? exp_cnt + 1 : 7;
        chk({lbl, tmo ? " R6 cyc_start after window two" : " R2 cyc_start after fourth answer"},
            int'(cyc_start), 1);
        chk({lbl, " R1 new_q"}, int'(new_q), int'(pass));
        chk({lbl, " R3 flag_early"}, int'(flag_early), int'(exp_fl[3]));
        chk({lbl, " R4 flag_wrong"}, int'(flag_wrong), int'(exp_fl[2]));
        chk({lbl, " R5 flag_seq"}, int'(flag_seq), int'(exp_fl[1]));
        chk({lbl, " R6 flag_tmo"}, int'(flag_tmo), int'(exp_fl[0]));
        chk({lbl, " R7 fail_cnt"}, int'(fail_cnt), exp_cnt);
        chk({lbl, " R9 fail_out"}, int'(fail_out), int'(exp_cnt > thr));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ans_vld = 1'b0; ans_ok = 1'b0; clr_req = 1'b0;
        win1_len = '0; win2_len = '0; fail_thr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset flags", int'({flag_early, flag_wrong, flag_seq, flag_tmo}), 0);
        chk("R7 reset fail_cnt", int'(fail_cnt), 0);
        chk("R1 reset new_q", int'(new_q), 0);
        rst = 1'b0;
        chk("R10 cyc_start after reset", int'(cyc_start), 1);
        exp_fl = 4'b0000;
        exp_cnt = 0;

        // R8: flags persist over a passing cycle; a clear on the closing tick keeps new events.
        clear_pat();
        run_cycle(3, 2, -1, 7, "R8 silent cycle");
        pat[0] = 1; pat[1] = 1; pat[2] = 1; pat[3] = 1;
        run_cycle(3, 2, -1, 7, "R8 pass keeps flags");
        clear_pat();
        pat[0] = 1; pat[1] = 1; pat[2] = 1;
        run_cycle(3, 2, 4, 7, "R8 clear on closing tick");

        // R10: zero lengths act as one tick each.
        clear_pat();
        run_cycle(0, 0, 0, 0, "R10 zero lengths");

        // R7: saturate the fail counter at its top.
        clear_pat();
        for (int k = 0; k < 9; k++) run_cycle(1, 1, 0, 5, "R7 saturate");

        // R1: passing cycles walk the counter to zero and hold it there.
        clear_pat();
        pat[0] = 1; pat[1] = 1; pat[2] = 1; pat[3] = 1;
        for (int k = 0; k < 9; k++) run_cycle(3, 1, 0, 2, "R1 floor");

        // R10: answers on the last tick of window one.
        clear_pat();
        pat[2] = 1; pat[3] = 1; pat[4] = 1; pat[5] = 1;
        run_cycle(3, 4, 0, 3, "R10 boundary short");
        clear_pat();
        pat[0] = 1; pat[1] = 1; pat[3] = 1; pat[4] = 1;
        run_cycle(4, 2, 0, 3, "R10 boundary pass");
        clear_pat();
        pat[0] = 1; pat[1] = 1; pat[2] = 1; pat[3] = 2;
        run_cycle(4, 2, 0, 3, "R10 boundary early");

        // Full sweep of every none/correct/incorrect pattern over 4 + 3 ticks.
        for (int p = 0; p < 2187; p++) begin
            int rem;
            clear_pat();
            rem = p;
            for (int d = 0; d < 7; d++) begin
                pat[d] = rem % 3;
                rem = rem / 3;
            end
            run_cycle(4, 3, 0, p % 8, "sweep");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule